// File: doc/BRIEF.md
# PHY Carrier Sense and Collision Indication

This block drives the carrier-sense and collision lines that a 10/100 Ethernet PHY presents to its MAC. It takes internal flags saying that the transmitter or the receiver is busy, together with the duplex setting, a power-down control and a repeater/node strap. From these it produces registered carrier and collision outputs. It also produces an output-enable for the receive-side MII outputs, which are data, clock, data-valid and error. That enable models the receive-enable tri-state control.

The repeater/node choice comes from a strap input that is shared with another pin function. It is captured once, on the first clock edge after reset is released. It then holds until the next reset, and it is visible on a mode output. In node mode running half duplex, the transmitter's own activity also raises carrier. In repeater mode or full duplex, only receive activity raises carrier. Collision can only occur in half duplex.

Top module: `phy_carrier_col`

## Requirements
- R1: In half-duplex node mode with power-down low, crs_o is high one cycle after a cycle in which tx_active_i or rx_active_i is high, and low otherwise.
- R2: In full duplex (full_duplex_i=1), or when repeater mode is latched (repeater_o=1), crs_o follows rx_active_i alone, one cycle later. tx_active_i has no effect on it.
- R3: In half duplex with power-down low, col_o is high one cycle after a cycle in which tx_active_i and rx_active_i are both high. This holds in either mode.
- R4: With full_duplex_i=1, col_o is low one cycle later, whatever the activity inputs are.
- R5: rpt_strap_i is sampled on the first rising clock edge after rst_ni goes high, with 0 selecting node mode and 1 selecting repeater mode. The latched value appears on repeater_o, and later changes of the strap have no effect until the next reset.
- R6: rx_oe_o equals rx_enable_i in the same cycle. Low means the receive-side outputs are in high impedance.
- R7: crs_o and col_o are registers with exactly one cycle of latency from their inputs.
- R8: With power_down_i=1, crs_o and col_o are low one cycle later, whatever the activity is.
- R9: While in reset, crs_o, col_o and repeater_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_active_i | input | 1 | Transmit activity flag |
| rx_active_i | input | 1 | Receive activity flag |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| power_down_i | input | 1 | 1 = power-down, which silences crs_o and col_o |
| rpt_strap_i | input | 1 | Repeater/node strap, sampled after reset |
| rx_enable_i | input | 1 | Receive output enable request |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision |
| rx_oe_o | output | 1 | Output enable for the receive-side MII outputs |
| repeater_o | output | 1 | Latched mode, 1 = repeater |

## Verification
The hardest case to reach is repeater mode, because the only way into it is a reset whose release happens while the strap is high. A strap change at any other time has to be ignored. The stimulus therefore applies reset several times, with the strap set to a chosen value at each release. After each release it toggles the strap at random, so that both modes are covered and a latch that keeps following the strap is caught. Within each mode, random activity, duplex and power-down patterns are mixed with directed cases where transmit and receive are both active.

// File: rtl/phy_cs_pkg.sv
package phy_cs_pkg;
  typedef enum logic {
    MODE_NODE = 1'b0,
    MODE_RPT  = 1'b1
  } phy_mode_e;
endpackage

// File: rtl/phy_mode_strap.sv
module phy_mode_strap
  import phy_cs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strap_i,
  output phy_mode_e mode_o
);
  logic      sampled_q;
  phy_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sampled_q <= 1'b0;
      mode_q    <= MODE_NODE;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      mode_q    <= strap_i ? MODE_RPT : MODE_NODE;
    end
  end

  assign mode_o = mode_q;

  // R5
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(mode_q));
endmodule

// File: rtl/phy_cs_gen.sv
module phy_cs_gen
  import phy_cs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tx_act_i,
  input  logic      rx_act_i,
  input  logic      fdx_i,
  input  logic      pdn_i,
  input  phy_mode_e mode_i,
  output logic      crs_o,
  output logic      col_o
);
  logic own_tx_sense;
  logic crs_d, col_d;
  logic crs_q, col_q;

  // own transmit counts only in half-duplex node mode
  assign own_tx_sense = tx_act_i && !fdx_i && (mode_i == MODE_NODE);
  assign crs_d = !pdn_i && (rx_act_i || own_tx_sense);
  assign col_d = !pdn_i && !fdx_i && tx_act_i && rx_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= crs_d;
      col_q <= col_d;
    end
  end

  assign crs_o = crs_q;
  assign col_o = col_q;

  // R4
  fdx_col_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdx_i |=> !col_o);
  // R8
  pdn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> (!crs_o && !col_o));
  // R2
  rx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && (fdx_i || mode_i == MODE_RPT)) |=> (crs_o == $past(rx_act_i)));
  // R3
  hdx_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && !fdx_i && tx_act_i && rx_act_i) |=> col_o);
endmodule

// File: rtl/phy_carrier_col.sv
module phy_carrier_col
  import phy_cs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic rx_active_i,
  input  logic full_duplex_i,
  input  logic power_down_i,
  input  logic rpt_strap_i,
  input  logic rx_enable_i,
  output logic crs_o,
  output logic col_o,
  output logic rx_oe_o,
  output logic repeater_o
);
  phy_mode_e mode;

  phy_mode_strap i_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (rpt_strap_i),
    .mode_o  (mode)
  );

  phy_cs_gen i_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_act_i (tx_active_i),
    .rx_act_i (rx_active_i),
    .fdx_i    (full_duplex_i),
    .pdn_i    (power_down_i),
    .mode_i   (mode),
    .crs_o    (crs_o),
    .col_o    (col_o)
  );

  assign rx_oe_o    = rx_enable_i;
  assign repeater_o = (mode == MODE_RPT);

  // R9
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!crs_o && !col_o && !repeater_o));
  // R1
  hdx_node_crs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!power_down_i && !full_duplex_i && !repeater_o && tx_active_i) |=> crs_o);
endmodule

// File: tb/test_phy_carrier_col.sv
module test_phy_carrier_col;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_a = 1'b0, rx_a = 1'b0, fdx = 1'b0, pdn = 1'b0, strap = 1'b0, rx_en = 1'b0;
  logic crs, col, rx_oe, rpt;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  phy_carrier_col i_phy_carrier_col (
    .clk_i(clk), .rst_ni(rst_n), .tx_active_i(tx_a), .rx_active_i(rx_a),
    .full_duplex_i(fdx), .power_down_i(pdn), .rpt_strap_i(strap),
    .rx_enable_i(rx_en), .crs_o(crs), .col_o(col), .rx_oe_o(rx_oe),
    .repeater_o(rpt)
  );

  function automatic logic exp_crs(logic t, logic r, logic f, logic p, logic m);
    if (p) return 1'b0;
    if (f || m) return r;
    return t | r;
  endfunction

  function automatic logic exp_col(logic t, logic r, logic f, logic p);
    return !p && !f && t && r;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(logic t, logic r, logic f, logic p, logic e, logic m);
    string rq_c, rq_l;
    tx_a = t; rx_a = r; fdx = f; pdn = p; rx_en = e;
    #1;
    chk("R6 rx_oe", rx_oe, e);
    @(negedge clk);
    rq_c = p ? "R8 crs" : ((f || m) ? "R2 crs" : "R1/R7 crs");
    rq_l = p ? "R8 col" : (f ? "R4 col" : "R3/R7 col");
    chk(rq_c, crs, exp_crs(t, r, f, p, m));
    chk(rq_l, col, exp_col(t, r, f, p));
  endtask

  task automatic do_reset(logic s);
    rst_n = 1'b0; tx_a = 1'b0; rx_a = 1'b0; pdn = 1'b0; strap = s;
    @(negedge clk); @(negedge clk);
    chk("R9 crs", crs, 1'b0);
    chk("R9 col", col, 1'b0);
    chk("R9 repeater", rpt, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 strap latch", rpt, s);
    strap = ~s;
  endtask

  initial begin
    logic m;
    void'($urandom(32'd4242));
    @(negedge clk);
    for (int pass = 0; pass < 4; pass++) begin
      m = pass[0];
      do_reset(m);
      // directed corners
      step(1, 1, 0, 0, 1, m);
      step(1, 0, 0, 0, 1, m);
      step(1, 1, 1, 0, 0, m);
      step(1, 1, 0, 1, 1, m);
      step(0, 1, 1, 0, 1, m);
      for (int i = 0; i < 400; i++) begin
        strap = 1'($urandom);
        step(1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 8) == 0, 1'($urandom), m);
      end
      chk("R5 strap ignored", rpt, m);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule